// File: doc/BRIEF.md
# Graphics/CPU Power Bias Controller

This block splits a shared power budget between the CPU cores and the integrated graphics using a closed control loop. It replaces a fixed split. The output `bias_o` is the percentage of the budget given to graphics. The CPU gets the rest, `100 - bias_o`.

On each evaluation tick the block compares the measured CPU/ring frequency with a floor. The floor is the workload-derived target frequency minus a programmable guard band. When the measured frequency is below the floor, the CPU is short of power, and the bias steps toward the CPU (the graphics share drops). Otherwise it steps toward the graphics.

A hysteresis counter stops the bias from oscillating. After the direction has been set, a reversal needs the opposite condition on a programmable number of consecutive ticks. Every adjustment has a bounded step size, and the bias is clamped to the range 0 to 100.

Top module: `gpu_bias_ctrl`

## Requirements
- R1: `bias_o` is the graphics share in percent. It never exceeds 100.
- R2: While `rst_ni` is low, `bias_o` equals the parameter `INIT_BIAS` (default 50). After reset, the remembered direction is toward graphics and the opposing-tick streak is zero.
- R3: `bias_o` changes only at a rising clock edge where `tick_i` is high. It updates at that same edge.
- R4: A tick needs the CPU when `actual_freq_i < target_freq_i - guard_band_i`. This subtraction saturates at zero, so when `guard_band_i >= target_freq_i` the tick always favours graphics. Frequencies are 8-bit values in 100 MHz units.
- R5: A move toward the CPU lowers `bias_o` by the effective step, clamped at 0.
- R6: A move toward graphics raises `bias_o` by the effective step, clamped at 100.
- R7: The effective step is `step_i` when it is between 1 and 8. A value of 0 acts as 1, and any value above 8 acts as 8. No tick changes the bias by more than 8.
- R8: A tick whose condition agrees with the remembered direction moves the bias and clears the streak. A tick that opposes it holds the bias and extends the streak. On the Nth consecutive opposing tick, the direction flips and the bias moves in the new direction. N is `hyst_i`, and a `hyst_i` of 0 acts as 1.
- R9: A tick never moves the bias against that tick's own condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Evaluation tick, one cycle wide |
| target_freq_i | input | 8 | Target CPU/ring frequency, 100 MHz units |
| actual_freq_i | input | 8 | Measured CPU/ring frequency, 100 MHz units |
| guard_band_i | input | 8 | Guard band subtracted from the target |
| step_i | input | 4 | Step size in percent per tick |
| hyst_i | input | 4 | Opposing ticks needed to reverse direction |
| bias_o | output | 7 | Graphics share of the budget, percent |

## Verification
The hardest state to reach from the ports is a partial opposing streak that is broken by an agreeing tick. The only sign that the streak was cleared is that a later reversal needs the full count again. The stimulus table builds a streak of one and inserts an agreeing tick. It then shows that one more opposing tick still holds the bias, and that only the second one flips it. A reset applied in the middle of a run is followed by an opposing tick, to show that the direction and the streak return to their reset values and not only the bias.

// File: rtl/gpu_bias_pkg.sv
package gpu_bias_pkg;
  typedef enum logic {
    DIR_GPU = 1'b0,
    DIR_CPU = 1'b1
  } bias_dir_e;
endpackage

// File: rtl/bias_cmp.sv
module bias_cmp #(
  parameter int unsigned FREQ_W = 8
) (
  input  logic [FREQ_W-1:0] target_i,
  input  logic [FREQ_W-1:0] actual_i,
  input  logic [FREQ_W-1:0] guard_i,
  output logic              need_cpu_o
);
  logic [FREQ_W-1:0] floor_w;

  // target minus guard, saturating at zero
  always_comb begin
    floor_w    = (target_i > guard_i) ? (target_i - guard_i) : '0;
    need_cpu_o = (actual_i < floor_w);
  end
endmodule

// File: rtl/bias_hyst.sv
module bias_hyst
  import gpu_bias_pkg::*;
#(
  parameter int unsigned HYST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  bias_dir_e         want_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              move_o
);
  bias_dir_e         dir_q;
  logic [HYST_W-1:0] streak_q;
  logic [HYST_W-1:0] limit_w;
  logic [HYST_W:0]   streak_nx_w;
  logic              agree_w, flip_w;

  always_comb begin
    limit_w     = (hyst_i == '0) ? HYST_W'(1) : hyst_i;
    streak_nx_w = {1'b0, streak_q} + 1'b1;
    agree_w     = (want_i == dir_q);
    flip_w      = !agree_w && (streak_nx_w >= {1'b0, limit_w});
    move_o      = tick_i && (agree_w || flip_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= DIR_GPU;
      streak_q <= '0;
    end else if (tick_i) begin
      if (agree_w) begin
        streak_q <= '0;
      end else if (flip_w) begin
        dir_q    <= want_i;
        streak_q <= '0;
      end else begin
        streak_q <= streak_nx_w[HYST_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bias_step.sv
module bias_step #(
  parameter int unsigned BIAS_W   = 7,
  parameter int unsigned STEP_W   = 4,
  parameter int unsigned BIAS_MAX = 100,
  parameter int unsigned STEP_MAX = 8
) (
  input  logic [BIAS_W-1:0] bias_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              to_cpu_i,
  output logic [BIAS_W-1:0] bias_o
);
  localparam logic [BIAS_W:0] MAX_W = (BIAS_W+1)'(BIAS_MAX);

  logic [STEP_W-1:0] step_eff_w;
  logic [BIAS_W:0]   step_x_w, sum_w;

  always_comb begin
    if (step_i == '0)                      step_eff_w = STEP_W'(1);
    else if (step_i > STEP_W'(STEP_MAX))   step_eff_w = STEP_W'(STEP_MAX);
    else                                   step_eff_w = step_i;
    step_x_w = (BIAS_W+1)'(step_eff_w);
    sum_w    = {1'b0, bias_i} + step_x_w;
    if (to_cpu_i)
      bias_o = ({1'b0, bias_i} > step_x_w) ? bias_i - step_x_w[BIAS_W-1:0] : '0;
    else
      bias_o = (sum_w > MAX_W) ? MAX_W[BIAS_W-1:0] : sum_w[BIAS_W-1:0];
  end
endmodule

// File: rtl/gpu_bias_ctrl.sv
module gpu_bias_ctrl
  import gpu_bias_pkg::*;
#(
  parameter int unsigned FREQ_W    = 8,
  parameter int unsigned BIAS_W    = 7,
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned HYST_W    = 4,
  parameter int unsigned BIAS_MAX  = 100,
  parameter int unsigned STEP_MAX  = 8,
  parameter int unsigned INIT_BIAS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FREQ_W-1:0] target_freq_i,
  input  logic [FREQ_W-1:0] actual_freq_i,
  input  logic [FREQ_W-1:0] guard_band_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic [BIAS_W-1:0] bias_o
);
  logic              need_cpu_w, move_w;
  logic [BIAS_W-1:0] bias_q, bias_nx_w;
  bias_dir_e         want_w;

  bias_cmp #(.FREQ_W(FREQ_W)) i_cmp (
    .target_i   (target_freq_i),
    .actual_i   (actual_freq_i),
    .guard_i    (guard_band_i),
    .need_cpu_o (need_cpu_w)
  );

  assign want_w = need_cpu_w ? DIR_CPU : DIR_GPU;

  bias_hyst #(.HYST_W(HYST_W)) i_hyst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .want_i (want_w),
    .hyst_i (hyst_i),
    .move_o (move_w)
  );

  bias_step #(
    .BIAS_W(BIAS_W), .STEP_W(STEP_W), .BIAS_MAX(BIAS_MAX), .STEP_MAX(STEP_MAX)
  ) i_step (
    .bias_i   (bias_q),
    .step_i   (step_i),
    .to_cpu_i (need_cpu_w),
    .bias_o   (bias_nx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bias_q <= BIAS_W'(INIT_BIAS);
    else if (move_w) bias_q <= bias_nx_w;
  end

  assign bias_o = bias_q;
endmodule

// File: rtl/gpu_bias_chk.sv
module gpu_bias_chk #(
  parameter int unsigned FREQ_W   = 8,
  parameter int unsigned BIAS_W   = 7,
  parameter int unsigned BIAS_MAX = 100,
  parameter int unsigned STEP_MAX = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [FREQ_W-1:0] target_freq_i,
  input logic [FREQ_W-1:0] actual_freq_i,
  input logic [FREQ_W-1:0] guard_band_i,
  input logic [BIAS_W-1:0] bias_o
);
  logic cpu_short;
  assign cpu_short = ({1'b0, actual_freq_i} + {1'b0, guard_band_i}) < {1'b0, target_freq_i};

  assert_bias_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(bias_o) <= BIAS_MAX);

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(bias_o));

  assert_no_rise_cpu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cpu_short) |=> (bias_o <= $past(bias_o)));

  assert_no_fall_gpu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cpu_short) |=> (bias_o >= $past(bias_o)));

  assert_step_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ((32'(bias_o) + STEP_MAX >= 32'($past(bias_o))) &&
                (32'($past(bias_o)) + STEP_MAX >= 32'(bias_o))));
endmodule

bind gpu_bias_ctrl gpu_bias_chk #(
  .FREQ_W(FREQ_W), .BIAS_W(BIAS_W), .BIAS_MAX(BIAS_MAX), .STEP_MAX(STEP_MAX)
) i_gpu_bias_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .target_freq_i (target_freq_i),
  .actual_freq_i (actual_freq_i),
  .guard_band_i  (guard_band_i),
  .bias_o        (bias_o)
);

// File: tb/test_gpu_bias_ctrl.sv
module test_gpu_bias_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] target_freq_i = '0, actual_freq_i = '0, guard_band_i = '0;
  logic [3:0] step_i = 4'd1, hyst_i = 4'd1;
  logic [6:0] bias_o;
  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  gpu_bias_ctrl i_gpu_bias_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .target_freq_i(target_freq_i), .actual_freq_i(actual_freq_i),
    .guard_band_i(guard_band_i), .step_i(step_i), .hyst_i(hyst_i),
    .bias_o(bias_o)
  );

  // act, tgt, guard, step, hyst, expected bias after the tick
  typedef struct packed {
    logic [7:0] act; logic [7:0] tgt; logic [7:0] gb;
    logic [3:0] step; logic [3:0] hyst; logic [6:0] exp;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd20, 8'd10, 8'd0,  4'd4,  4'd2, 7'd54},  // R6 move toward gpu
    '{8'd20, 8'd10, 8'd0,  4'd0,  4'd2, 7'd55},  // R7 step 0 acts as 1
    '{8'd20, 8'd10, 8'd0,  4'd15, 4'd2, 7'd63},  // R7 step clamps to 8
    '{8'd5,  8'd30, 8'd5,  4'd8,  4'd2, 7'd63},  // R8 opposing tick holds
    '{8'd5,  8'd30, 8'd5,  4'd8,  4'd2, 7'd55},  // R8 second opposing flips, R5
    '{8'd30, 8'd30, 8'd0,  4'd8,  4'd2, 7'd55},  // R4 equal is not short; R8 hold
    '{8'd5,  8'd30, 8'd5,  4'd8,  4'd2, 7'd47},  // R8 agreeing tick clears streak
    '{8'd30, 8'd30, 8'd0,  4'd8,  4'd2, 7'd47},  // R8 streak restarts: hold
    '{8'd30, 8'd30, 8'd0,  4'd8,  4'd2, 7'd55},  // R8 flip back to gpu
    '{8'd0,  8'd10, 8'd20, 4'd8,  4'd2, 7'd63},  // R4 saturated floor favours gpu
    '{8'd0,  8'd50, 8'd0,  4'd8,  4'd0, 7'd55},  // R8 hyst 0 acts as 1
    '{8'd60, 8'd50, 8'd0,  4'd8,  4'd1, 7'd63}   // R8 hyst 1 flips at once
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [7:0] a, t, g, input logic [3:0] s, h);
    actual_freq_i = a; target_freq_i = t; guard_band_i = g; step_i = s; hyst_i = h;
  endtask

  task automatic do_tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2 reset value", bias_o, 50);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      set_in(VECS[i].act, VECS[i].tgt, VECS[i].gb, VECS[i].step, VECS[i].hyst);
      do_tick();
      check($sformatf("R8 table vector %0d", i), bias_o, VECS[i].exp);
    end

    // R3: inputs favour cpu with hyst 1, but no tick is given
    set_in(8'd0, 8'd200, 8'd0, 4'd8, 4'd1);
    repeat (5) @(negedge clk_i);
    check("R3 no tick no change", bias_o, 63);

    // R6 clamp at 100
    set_in(8'd100, 8'd10, 8'd0, 4'd8, 4'd1);
    for (int i = 0; i < 8; i++) do_tick();
    check("R6 clamp high", bias_o, 100);
    check("R1 range", (bias_o <= 100) ? 1 : 0, 1);

    // R5 single step toward cpu
    set_in(8'd1, 8'd100, 8'd10, 4'd3, 4'd1);
    do_tick();
    check("R5 step down", bias_o, 97);
    set_in(8'd1, 8'd100, 8'd10, 4'd8, 4'd1);
    for (int i = 0; i < 20; i++) do_tick();
    check("R5 clamp low", bias_o, 0);

    // R9: gpu-favouring tick while cpu direction held, hyst 3 -> hold
    set_in(8'd90, 8'd50, 8'd0, 4'd8, 4'd3);
    do_tick();
    check("R9 opposing tick no move", bias_o, 0);

    // R2: mid-run reset restores bias, gpu direction, zero streak
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R2 mid-run reset", bias_o, 50);
    rst_ni = 1'b1;
    @(negedge clk_i);
    set_in(8'd0, 8'd50, 8'd0, 4'd8, 4'd2);
    do_tick();
    check("R2 direction reset to gpu", bias_o, 50);
    do_tick();
    check("R2 streak reset to zero", bias_o, 42);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule